// File: doc/BRIEF.md
# Scan Inversion Mode Selector

This block takes in one fully specified test pattern, one bit per cycle. Each bit is a value that the combinational logic behind a scan chain has to see. The block then decides how that pattern should be shifted in. There are two options. In buffer mode the chain links pass bits unchanged, so the scan-in sequence is the pattern itself. In inverter mode every other link inverts, so the scan-in sequence is the pattern XOR an alternating mask. The block counts the adjacent-bit transitions each option would cause during shifting and picks the cheaper one. On a tie it picks buffer mode.

The pattern is kept in an internal N-bit register. One cycle after the last bit arrives, the block raises a one-cycle `done` pulse and presents the two transition counts and the select bit. The next N cycles stream the scan-in sequence for the chosen mode, with index 0 first. While the decision and the stream are in progress, new input is ignored. The next pattern is accepted from the cycle after the final stream bit.

The controller has three states:
- `ST_LOAD` collects bits. It moves to `ST_DECIDE` when the Nth bit is accepted.
- `ST_DECIDE` is the one-cycle decision state. It always moves to `ST_STREAM`.
- `ST_STREAM` emits N bits. It returns to `ST_LOAD` after the bit at index N-1.

Top module: `scan_inv_sel`

## Requirements
- R1: After reset, `done`, `out_vld`, `out_last` and `sel_inv` are 0, and both counts are 0.
- R2: In `ST_LOAD`, each cycle with `in_vld` high stores `in_bit` at the next index, starting from index 0. In the cycle after the Nth accepted bit, `done` is 1 for exactly one cycle.
- R3: At `done`, `buf_cnt` equals the number of positions i (0 ≤ i < N-1) where target bit i differs from target bit i+1.
- R4: At `done`, `inv_cnt` equals the transition count of the target XOR a mask whose bit i is 1 when i is even and 0 when i is odd.
- R5: At `done`, `buf_cnt + inv_cnt` equals N-1 for every pattern.
- R6: `sel_inv` is 1 only when `inv_cnt` is strictly less than `buf_cnt`. A tie gives 0, and an all-zero pattern gives 0.
- R7: In the N cycles right after `done`, `out_vld` is 1 and `out_bit` carries scan-in bit i in cycle i. That bit is target bit i when `sel_inv` is 0, and target bit i XOR the mask bit when `sel_inv` is 1. `out_last` is 1 only with index N-1.
- R8: `in_vld` has no effect from `done` up to and including the `out_last` cycle. The next pattern's index 0 is the first bit accepted after that.
- R9: Both counts restart from zero at the first bit of each pattern, so no value carries over from the previous pattern.
- R10: `buf_cnt`, `inv_cnt` and `sel_inv` hold their values from `done` through the last stream cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Pattern bit valid |
| in_bit | input | 1 | Pattern bit, index 0 first |
| done | output | 1 | One-cycle decision pulse |
| sel_inv | output | 1 | 1 = inverter mode, 0 = buffer mode |
| buf_cnt | output | CW | Transitions when shifting the pattern itself |
| inv_cnt | output | CW | Transitions when shifting the masked pattern |
| out_vld | output | 1 | Scan-in stream bit valid |
| out_bit | output | 1 | Scan-in stream bit |
| out_last | output | 1 | Final stream bit |

CW is ceil(log2(N)).

## Verification
The bench builds the block with N = 9, which makes the counter width 4 bits. Because N-1 = 8 is even, an exact tie between the two counts is possible, so the tie rule of R6 is exercised. The patterns applied are:
- all zeros and all ones,
- both alternating patterns (strict inverter wins),
- a tie pattern,
- pseudo-random patterns.

For several patterns, `in_vld` is held high with random data throughout the decision and stream phases. Any leak of that input into the next pattern would show up in its counts or stream.

// File: rtl/sis_pkg.sv
package sis_pkg;
    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_STREAM = 2'd2
    } sis_state_e;
endpackage

// File: rtl/sis_edge_counter.sv
module sis_edge_counter #(
    parameter int N  = 16,
    parameter int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          first,
    input  logic          bit_in,
    output logic [CW-1:0] buf_c,
    output logic [CW-1:0] inv_c
);
    logic prev_q;

    // A differing neighbour pair is a transition of the raw pattern.
    // Under the alternating mask, only an equal pair becomes a transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            buf_c  <= '0;
            inv_c  <= '0;
        end else if (step) begin
            prev_q <= bit_in;
            if (first) begin
                buf_c <= '0;
                inv_c <= '0;
            end else if (bit_in != prev_q) begin
                buf_c <= buf_c + 1'b1;
            end else begin
                inv_c <= inv_c + 1'b1;
            end
        end
    end

    AST_CLR_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (step && first) |=> (buf_c == '0 && inv_c == '0)); // R9
endmodule

// File: rtl/sis_pattern_buf.sv
module sis_pattern_buf #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic          wr_bit,
    output logic          rd_bit
);
    logic [N-1:0] pat_q;

    for (genvar g = 0; g < N; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pat_q[g] <= 1'b0;
            else if (wr_en && idx == IW'(g))
                pat_q[g] <= wr_bit;
        end
    end

    assign rd_bit = pat_q[idx];
endmodule

// File: rtl/scan_inv_sel.sv
module scan_inv_sel #(
    parameter int N  = 16,
    parameter int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_bit,
    output logic          done,
    output logic          sel_inv,
    output logic [CW-1:0] buf_cnt,
    output logic [CW-1:0] inv_cnt,
    output logic          out_vld,
    output logic          out_bit,
    output logic          out_last
);
    import sis_pkg::*;

    localparam int             IW   = CW;
    localparam logic [IW-1:0]  LAST = IW'(N - 1);

    sis_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic          accept;
    logic          rd_bit;

    assign accept = (state_q == ST_LOAD) && in_vld;

    sis_edge_counter #(.N(N), .CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (accept),
        .first  (idx_q == '0),
        .bit_in (in_bit),
        .buf_c  (buf_cnt),
        .inv_c  (inv_cnt)
    );

    sis_pattern_buf #(.N(N), .IW(IW)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept),
        .idx    (idx_q),
        .wr_bit (in_bit),
        .rd_bit (rd_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_LOAD: begin
                if (in_vld) begin
                    if (idx_q == LAST) begin
                        idx_d   = '0;
                        state_d = ST_DECIDE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_DECIDE: state_d = ST_STREAM;
            ST_STREAM: begin
                if (idx_q == LAST) begin
                    idx_d   = '0;
                    state_d = ST_LOAD;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = ST_LOAD;
        endcase
    end

    // Outputs; the mask bit is 1 at even stream positions
    always_comb begin
        done     = 1'b0;
        out_vld  = 1'b0;
        out_last = 1'b0;
        sel_inv  = (inv_cnt < buf_cnt);
        out_bit  = 1'b0;
        unique case (state_q)
            ST_LOAD:   ;
            ST_DECIDE: done = 1'b1;
            ST_STREAM: begin
                out_vld  = 1'b1;
                out_last = (idx_q == LAST);
                out_bit  = rd_bit ^ (sel_inv & ~idx_q[0]);
            end
            default: ;
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_CNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({1'b0, buf_cnt} + {1'b0, inv_cnt}) == (CW+1)'(N - 1)); // R5
    AST_STREAM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> out_vld); // R7
    AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ($stable(buf_cnt) && $stable(inv_cnt) && $stable(sel_inv))); // R10
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_vld); // R8
    AST_NO_IDLE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> !done); // R7
endmodule

// File: tb/scan_inv_sel_tb.sv
module scan_inv_sel_tb;
    localparam int N  = 9;
    localparam int CW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic          in_bit = 1'b0;
    logic          done, sel_inv, out_vld, out_bit, out_last;
    logic [CW-1:0] buf_cnt, inv_cnt;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [2*CW:0] dec_q[$];
    logic [1:0]    bit_q[$];
    logic [2*CW:0] cur_dec;

    always #10 clk = ~clk;

    scan_inv_sel #(.N(N), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bit(in_bit),
        .done(done), .sel_inv(sel_inv), .buf_cnt(buf_cnt), .inv_cnt(inv_cnt),
        .out_vld(out_vld), .out_bit(out_bit), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: computes expectations and pushes them before sending the bits.
    task automatic send(input logic [N-1:0] p, input bit junk);
        int b = 0;
        int v = 0;
        logic s;
        for (int i = 0; i < N-1; i++) begin
            if (p[i] != p[i+1]) b++;
            if ((p[i] ^ ((i % 2) == 0)) != (p[i+1] ^ (((i+1) % 2) == 0))) v++;
        end
        s = (v < b);
        dec_q.push_back({s, CW'(b), CW'(v)});
        for (int i = 0; i < N; i++)
            bit_q.push_back({(s ? (p[i] ^ ((i % 2) == 0)) : p[i]), (i == N-1)});
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            in_vld = 1'b1;
            in_bit = p[i];
        end
        forever begin
            @(negedge clk);
            if (out_last) begin
                in_vld = 1'b0;
                break;
            end
            in_vld = junk;
            in_bit = junk ? 1'($urandom) : 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (dec_q.size() == 0) begin
                    check(1'b0, "R2 unexpected done", 1, 0);
                end else begin
                    cur_dec = dec_q.pop_front();
                    check(buf_cnt == cur_dec[2*CW-1:CW], "R3 buf_cnt", buf_cnt, cur_dec[2*CW-1:CW]);
                    check(inv_cnt == cur_dec[CW-1:0], "R4 inv_cnt", inv_cnt, cur_dec[CW-1:0]);
                    check(int'(buf_cnt) + int'(inv_cnt) == N-1, "R5 count sum",
                          int'(buf_cnt) + int'(inv_cnt), N-1);
                    check(sel_inv == cur_dec[2*CW], "R6 sel_inv", sel_inv, cur_dec[2*CW]);
                end
            end
            if (out_vld) begin
                if (bit_q.size() == 0) begin
                    check(1'b0, "R7 unexpected stream bit", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = bit_q.pop_front();
                    check(out_bit == e[1], "R7 out_bit", out_bit, e[1]);
                    check(out_last == e[0], "R7 out_last", out_last, e[0]);
                    check(sel_inv == cur_dec[2*CW] && buf_cnt == cur_dec[2*CW-1:CW]
                          && inv_cnt == cur_dec[CW-1:0], "R10 hold", sel_inv, cur_dec[2*CW]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "watchdog", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 1'b0 && out_vld == 1'b0 && out_last == 1'b0, "R1 flags", done, 0);
        check(sel_inv == 1'b0 && buf_cnt == '0 && inv_cnt == '0, "R1 counts", buf_cnt, 0);
        rst_n = 1'b1;
        send(9'b000000000, 1'b0);   // R6 all-zero -> buffer
        send(9'b111111111, 1'b1);   // R8 junk during stream
        send(9'b101010101, 1'b0);   // inverter strictly wins
        send(9'b010101010, 1'b1);
        send(9'b001100110, 1'b0);   // R6 tie: 4 vs 4 -> buffer
        send(9'b000000000, 1'b1);   // R9 counts restart after alternating data
        for (int k = 0; k < 8; k++)
            send(N'($urandom), k[0]);
        repeat (4) @(negedge clk);
        check(dec_q.size() == 0 && bit_q.size() == 0, "R2 all results seen",
              dec_q.size() + bit_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule